// File: doc/BRIEF.md
# Three-LUT Configurable Logic Cell

The cell is one logic element of a lookup-table-based programmable array. Two 4-input truth tables (F and G) each evaluate any Boolean function of their own four inputs. A third, 3-input table (H) combines them: its two upper inputs are steered by configuration bits from either the F/G results or cell pins, and its lowest input is always the pin `h1_i`. This cascade yields any function of five inputs, and some functions of up to nine inputs, such as 9-bit parity.

The cell has two combinational outputs and two storage elements. Each storage element picks its data from its own table path, from H, or from the direct data pin. The two elements share the clock, clock enable and local set/reset. Each element also has its own clock-inversion bit and its own set/reset value. A single mode bit turns both elements into level-sensitive latches. A global set/reset pin forces both elements to their set/reset values. Because only two unregistered results leave the cell, a third independent function has to be taken out through a storage element.

All truth tables and steering bits come from a serial configuration chain. It loads while `cfg_en_i` is high and holds its value otherwise.

Top module: `lut_cell3`

## Requirements
- R1: The configuration word is 53 bits wide. On each rising `clk_i` edge with `cfg_en_i` high, the word shifts up by one and `cfg_sdi_i` enters bit 0. With `cfg_en_i` low the word holds. Bit fields: F table [15:0], G table [31:16], H table [39:32], H-A source [40], H-B source [41], X output select [42], Y output select [43], X store source [45:44], Y store source [47:46], X clock invert [48], Y clock invert [49], latch mode [50], X set/reset value [51], Y set/reset value [52].
- R2: With the output select at 0, `x_o` equals F table bit {f_i[3],f_i[2],f_i[1],f_i[0]} and `y_o` equals G table bit {g_i[3..0]}, for any table contents.
- R3: The H table index is {B,A,`h1_i`}, where A is the F result (source bit 0) or `din_i` (1), and B is the G result (0) or `sr_i` (1). An output select of 1 routes the H result to `x_o` or `y_o`.
- R4: Through the cascade, the cell computes any function of five inputs (H selecting between F and G on `h1_i`) and 9-input parity, over all 512 combinations of `f_i`, `g_i` and `h1_i`.
- R5: The store source code selects the element's data: 0 gives its own table result (F for X, G for Y), 1 gives the H result, and 2 or 3 give `din_i`.
- R6: In edge mode, an element captures its data on the rising edge of `clk_i` XOR its clock-invert bit, so an inverted element updates on the falling edge of `clk_i`.
- R7: While `ce_i` is low, neither element changes on clock edges or latch openings.
- R8: In latch mode, each element is transparent while `clk_i` XOR its invert bit is high and `ce_i` is high, and holds otherwise.
- R9: While `gsr_i` or `sr_i` is high, each element is forced at once to its own set/reset value, whatever the clock and `ce_i` are doing.
- R10: Three independent functions come out together: F on `x_o`, G on `y_o`, and H through a storage element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock; also clocks the configuration chain |
| cfg_en_i | input | 1 | High to shift the configuration chain |
| cfg_sdi_i | input | 1 | Serial configuration data |
| f_i | input | 4 | F table address inputs |
| g_i | input | 4 | G table address inputs |
| h1_i | input | 1 | Fixed H table input |
| din_i | input | 1 | Direct data input |
| ce_i | input | 1 | Shared clock enable |
| sr_i | input | 1 | Shared local set/reset, active high |
| gsr_i | input | 1 | Global set/reset, active high |
| x_o | output | 1 | Combinational output X (F or H) |
| y_o | output | 1 | Combinational output Y (G or H) |
| xq_o | output | 1 | Storage element X output |
| yq_o | output | 1 | Storage element Y output |

## Verification
The hardest case to reach is one where the two storage elements act on opposite clock phases inside the same cycle. Examples are an inverted latch opening while its neighbour is closed, or an inverted flop capturing on the falling edge while the other waits for the rising edge. Reaching it needs a full 53-bit reload for each configuration. The stimulus then changes the data mid-phase and samples both outputs shortly after each edge of `clk_i`. That separates which element moved on which edge.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int FG_INPUTS = 4;
  localparam int H_INPUTS  = 3;
  localparam int FG_DEPTH  = 1 << FG_INPUTS;
  localparam int H_DEPTH   = 1 << H_INPUTS;
  localparam int N_STORE   = 2;

  typedef enum logic [1:0] {
    SRC_OWN = 2'd0,
    SRC_H   = 2'd1,
    SRC_DIN = 2'd2,
    SRC_DI2 = 2'd3
  } store_src_e;

  // Packed from MSB to LSB; bit 0 is the last bit shifted in.
  typedef struct packed {
    logic                srv_y;
    logic                srv_x;
    logic                lat_en;
    logic                inv_y;
    logic                inv_x;
    store_src_e          src_y;
    store_src_e          src_x;
    logic                ysel_h;
    logic                xsel_h;
    logic                b_from_sr;
    logic                a_from_din;
    logic [H_DEPTH-1:0]  h_tab;
    logic [FG_DEPTH-1:0] g_tab;
    logic [FG_DEPTH-1:0] f_tab;
  } cell_cfg_t;

  localparam int CFG_BITS = $bits(cell_cfg_t);
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic         sdi,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (en) word <= {word[W-2:0], sdi};
  end
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter  int N = 4,
  localparam int D = 1 << N
) (
  input  logic [D-1:0] tab,
  input  logic [N-1:0] sel,
  output logic         o
);
  assign o = tab[sel];
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
  input  logic clk,
  input  logic inv,
  input  logic lat_en,
  input  logic ce,
  input  logic clr,
  input  logic clr_val,
  input  logic d,
  output logic q
);
  logic ck_eff;
  logic ff_q;
  logic lat_q;

  assign ck_eff = clk ^ inv;

  // Edge-triggered path; re-applies clr_val on every edge while cleared.
  always_ff @(posedge ck_eff or posedge clr) begin
    if (clr)     ff_q <= clr_val;
    else if (ce) ff_q <= d;
  end

  // Level-sensitive path, open while the effective clock is high.
  always_latch begin
    if (clr)               lat_q = clr_val;
    else if (ck_eff && ce) lat_q = d;
  end

  assign q = lat_en ? lat_q : ff_q;
endmodule

// File: rtl/lut_cell3.sv
module lut_cell3
  import lcell_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 cfg_en_i,
  input  logic                 cfg_sdi_i,
  input  logic [FG_INPUTS-1:0] f_i,
  input  logic [FG_INPUTS-1:0] g_i,
  input  logic                 h1_i,
  input  logic                 din_i,
  input  logic                 ce_i,
  input  logic                 sr_i,
  input  logic                 gsr_i,
  output logic                 x_o,
  output logic                 y_o,
  output logic                 xq_o,
  output logic                 yq_o
);
  logic [CFG_BITS-1:0] cfg_word;
  cell_cfg_t           cfg;
  logic                f_out, g_out, h_out, h_a, h_b, clr;
  logic [N_STORE-1:0]  own_v, inv_v, srv_v, d_v, q_v;
  store_src_e          src_v [N_STORE];

  lcell_cfg_chain #(.W(CFG_BITS)) u_chain (
    .clk(clk_i), .en(cfg_en_i), .sdi(cfg_sdi_i), .word(cfg_word)
  );
  assign cfg = cell_cfg_t'(cfg_word);

  lcell_lut #(.N(FG_INPUTS)) u_flut (.tab(cfg.f_tab), .sel(f_i), .o(f_out));
  lcell_lut #(.N(FG_INPUTS)) u_glut (.tab(cfg.g_tab), .sel(g_i), .o(g_out));

  assign h_a = cfg.a_from_din ? din_i : f_out;
  assign h_b = cfg.b_from_sr  ? sr_i  : g_out;
  lcell_lut #(.N(H_INPUTS)) u_hlut (.tab(cfg.h_tab), .sel({h_b, h_a, h1_i}), .o(h_out));

  assign x_o = cfg.xsel_h ? h_out : f_out;
  assign y_o = cfg.ysel_h ? h_out : g_out;

  assign clr      = gsr_i | sr_i;
  assign own_v    = {g_out, f_out};
  assign inv_v    = {cfg.inv_y, cfg.inv_x};
  assign srv_v    = {cfg.srv_y, cfg.srv_x};
  assign src_v[0] = cfg.src_x;
  assign src_v[1] = cfg.src_y;

  for (genvar i = 0; i < N_STORE; i++) begin : g_store
    logic d_sel;
    always_comb begin
      case (src_v[i])
        SRC_OWN: d_sel = own_v[i];
        SRC_H:   d_sel = h_out;
        default: d_sel = din_i;
      endcase
    end
    assign d_v[i] = d_sel;

    lcell_store u_store (
      .clk(clk_i), .inv(inv_v[i]), .lat_en(cfg.lat_en), .ce(ce_i),
      .clr(clr), .clr_val(srv_v[i]), .d(d_v[i]), .q(q_v[i])
    );

    // R6
    capture_chk: assert property (@(posedge clk_i) disable iff (cfg_en_i)
      (!cfg.lat_en && !inv_v[i] && ce_i && !gsr_i && !sr_i)
      |=> (q_v[i] == $past(d_v[i]) || gsr_i || sr_i));

    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (cfg_en_i)
      (!cfg.lat_en && !inv_v[i] && !ce_i)
      |=> ($stable(q_v[i]) || gsr_i || sr_i));

    // R8
    latch_open_chk: assert property (@(posedge clk_i) disable iff (cfg_en_i)
      (cfg.lat_en && inv_v[i] && ce_i && !gsr_i && !sr_i) |-> (q_v[i] == d_v[i]));

    // R9
    gsr_force_chk: assert property (@(posedge clk_i)
      (gsr_i && $past(gsr_i) && !cfg_en_i && !$past(cfg_en_i)) |-> (q_v[i] == srv_v[i]));
  end

  assign xq_o = q_v[0];
  assign yq_o = q_v[1];
endmodule

// File: tb/tb_lut_cell3.sv
module tb_lut_cell3;
  logic       clk = 1'b0;
  logic       cfg_en, cfg_sdi, h1, din, ce, sr, gsr;
  logic [3:0] f_in, g_in;
  logic       x, y, xq, yq;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [15:0] ft, gt;
  logic [7:0]  ht;

  always #4 clk = ~clk;

  lut_cell3 dut (
    .clk_i(clk), .cfg_en_i(cfg_en), .cfg_sdi_i(cfg_sdi), .f_i(f_in), .g_i(g_in),
    .h1_i(h1), .din_i(din), .ce_i(ce), .sr_i(sr), .gsr_i(gsr),
    .x_o(x), .y_o(y), .xq_o(xq), .yq_o(yq)
  );

  function automatic logic [52:0] mk(logic [15:0] f, logic [15:0] g, logic [7:0] h,
      logic asel, logic bsel, logic xs, logic ys, logic [1:0] sx, logic [1:0] sy,
      logic ix, logic iy, logic lat, logic vx, logic vy);
    return {vy, vx, lat, iy, ix, sy, sx, ys, xs, bsel, asel, h, g, f};
  endfunction

  function automatic logic hexp(logic [15:0] f, logic [15:0] g, logic [7:0] h,
      logic [3:0] fi, logic [3:0] gi, logic hi);
    return h[{g[gi], f[fi], hi}];
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic load(input logic [52:0] w);
    cfg_en = 1'b1;
    for (int i = 52; i >= 0; i--) begin
      cfg_sdi = w[i];
      tick();
    end
    cfg_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cfg_en = 1'b1; cfg_sdi = 1'b0; f_in = '0; g_in = '0; h1 = 1'b0;
    din = 1'b0; ce = 1'b0; sr = 1'b0; gsr = 1'b1;

    // R9: reset state under global set/reset, both polarities
    load(mk(16'h0, 16'h0, 8'h0, 0, 0, 0, 0, 2'd2, 2'd2, 0, 0, 0, 1, 0));
    tick();
    chk("R9", "xq reset", xq, 1'b1);
    chk("R9", "yq reset", yq, 1'b0);
    load(mk(16'h0, 16'h0, 8'h0, 0, 0, 0, 0, 2'd2, 2'd2, 0, 0, 0, 0, 1));
    tick();
    chk("R9", "xq reset", xq, 1'b0);
    chk("R9", "yq reset", yq, 1'b1);

    // R1: field positions and hold while disabled
    load(mk(16'h8000, 16'h0001, 8'h00, 0, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0));
    f_in = 4'd15; g_in = 4'd15; #1;
    chk("R1", "x top bit", x, 1'b1);
    chk("R1", "y top bit", y, 1'b0);
    f_in = 4'd0; g_in = 4'd0; #1;
    chk("R1", "x bit0", x, 1'b0);
    chk("R1", "y bit0", y, 1'b1);
    for (int k = 0; k < 6; k++) begin
      cfg_sdi = ~cfg_sdi;
      tick();
    end
    chk("R1", "x after idle shift", x, 1'b0);
    chk("R1", "y after idle shift", y, 1'b1);

    // R2: random F and G tables, full sweep
    for (int t = 0; t < 8; t++) begin
      ft = 16'($urandom); gt = 16'($urandom);
      load(mk(ft, gt, 8'h0, 0, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0));
      for (int i = 0; i < 16; i++) begin
        f_in = 4'(i); g_in = 4'(15 - i); #1;
        chk("R2", "x=F", x, ft[i]);
        chk("R2", "y=G", y, gt[15 - i]);
      end
    end

    // R3: H cascade, random tables, all 512 combinations
    for (int t = 0; t < 6; t++) begin
      ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
      load(mk(ft, gt, ht, 0, 0, 1, 1, 2'd0, 2'd0, 0, 0, 0, 0, 0));
      for (int v = 0; v < 512; v++) begin
        {g_in, f_in, h1} = 9'(v); #1;
        chk("R3", "x=H", x, hexp(ft, gt, ht, f_in, g_in, h1));
        chk("R3", "y=H", y, hexp(ft, gt, ht, f_in, g_in, h1));
      end
    end

    // R3: H inputs taken from din and sr pins
    ht = 8'($urandom);
    load(mk(16'h0, 16'hFFFF, ht, 1, 1, 1, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0));
    for (int v = 0; v < 8; v++) begin
      {sr, din, h1} = 3'(v); #1;
      chk("R3", "x=H(sr,din,h1)", x, ht[v]);
      chk("R3", "y=G", y, 1'b1);
    end
    sr = 1'b0; din = 1'b0; h1 = 1'b0;

    // R4: nine-input parity
    load(mk(16'h6996, 16'h6996, 8'h96, 0, 0, 1, 0, 2'd0, 2'd0, 0, 0, 0, 0, 0));
    for (int v = 0; v < 512; v++) begin
      {g_in, f_in, h1} = 9'(v); #1;
      chk("R4", "parity9", x, ^(9'(v)));
    end

    // R4: five-input function, h1 choosing between F and G
    for (int t = 0; t < 4; t++) begin
      ft = 16'($urandom); gt = 16'($urandom);
      load(mk(ft, gt, 8'hE4, 0, 0, 1, 1, 2'd0, 2'd0, 0, 0, 0, 0, 0));
      for (int v = 0; v < 32; v++) begin
        {h1, f_in} = 5'(v); g_in = f_in; #1;
        chk("R4", "five-input", x, h1 ? gt[f_in] : ft[f_in]);
      end
    end
    h1 = 1'b0;

    // R6: X on rising edge, Y inverted on falling edge
    gsr = 1'b1;
    load(mk(16'h0, 16'h0, 8'h0, 0, 0, 0, 0, 2'd2, 2'd2, 0, 1, 0, 0, 0));
    gsr = 1'b0; ce = 1'b1; din = 1'b0;
    tick(); tick();
    din = 1'b1; #1;
    chk("R6", "xq before edges", xq, 1'b0);
    chk("R6", "yq before edges", yq, 1'b0);
    @(negedge clk); #1;
    chk("R6", "yq after falling", yq, 1'b1);
    chk("R6", "xq after falling", xq, 1'b0);
    @(posedge clk); #1;
    chk("R6", "xq after rising", xq, 1'b1);
    #1;
    din = 1'b0;
    @(negedge clk); #1;
    chk("R6", "yq falls", yq, 1'b0);
    chk("R6", "xq holds", xq, 1'b1);
    @(posedge clk); #1;
    chk("R6", "xq falls", xq, 1'b0);
    #1;

    // R7: clock enable low holds both elements
    ce = 1'b0; din = 1'b1;
    tick(); tick(); tick();
    chk("R7", "xq hold", xq, 1'b0);
    chk("R7", "yq hold", yq, 1'b0);
    ce = 1'b1;
    tick();
    chk("R7", "xq after enable", xq, 1'b1);
    chk("R7", "yq after enable", yq, 1'b1);

    // R5 and R10: X stores H, Y stores G, combinational F and G out
    ft = 16'($urandom); gt = 16'($urandom); ht = 8'($urandom);
    gsr = 1'b1;
    load(mk(ft, gt, ht, 0, 0, 0, 0, 2'd1, 2'd0, 0, 0, 0, 0, 0));
    gsr = 1'b0; ce = 1'b1;
    for (int k = 0; k < 16; k++) begin
      f_in = 4'($urandom); g_in = 4'($urandom); h1 = 1'($urandom); din = 1'($urandom);
      tick();
      chk("R5", "xq from H", xq, hexp(ft, gt, ht, f_in, g_in, h1));
      chk("R5", "yq from G", yq, gt[g_in]);
      chk("R10", "x=F", x, ft[f_in]);
      chk("R10", "y=G", y, gt[g_in]);
    end
    load(mk(ft, gt, ht, 0, 0, 0, 0, 2'd2, 2'd3, 0, 0, 0, 0, 0));
    for (int k = 0; k < 8; k++) begin
      din = k[0] ^ k[2];
      tick();
      chk("R5", "xq from din", xq, din);
      chk("R5", "yq from din (code 3)", yq, din);
    end

    // R8: latch mode, X open on high phase, Y open on low phase
    gsr = 1'b1;
    load(mk(16'h0, 16'h0, 8'h0, 0, 0, 0, 0, 2'd2, 2'd2, 0, 1, 1, 0, 1));
    din = 1'b0; ce = 1'b1; gsr = 1'b0; #1;
    chk("R8", "xq open high", xq, 1'b0);
    chk("R8", "yq closed high", yq, 1'b1);
    @(negedge clk); #1;
    chk("R8", "yq open low", yq, 1'b0);
    @(posedge clk); #2;
    din = 1'b1; #1;
    chk("R8", "xq follows", xq, 1'b1);
    chk("R8", "yq closed", yq, 1'b0);
    @(negedge clk); #2;
    din = 1'b0; #1;
    chk("R8", "xq closed low", xq, 1'b1);
    chk("R8", "yq follows", yq, 1'b0);
    ce = 1'b0; din = 1'b1; #1;
    chk("R8", "yq gated by ce", yq, 1'b0);
    ce = 1'b1;
    tick();

    // R9: local and global set/reset override clocking and enable
    gsr = 1'b1;
    load(mk(16'h0, 16'h0, 8'h0, 0, 0, 0, 0, 2'd2, 2'd2, 0, 0, 0, 1, 0));
    gsr = 1'b0; ce = 1'b1; din = 1'b0;
    tick();
    chk("R9", "xq released", xq, 1'b0);
    chk("R9", "yq released", yq, 1'b0);
    sr = 1'b1; #1;
    chk("R9", "xq sr immediate", xq, 1'b1);
    chk("R9", "yq sr immediate", yq, 1'b0);
    din = 1'b1;
    tick();
    chk("R9", "xq sr over edge", xq, 1'b1);
    chk("R9", "yq sr over edge", yq, 1'b0);
    sr = 1'b0;
    tick();
    chk("R9", "xq after sr", xq, 1'b1);
    chk("R9", "yq after sr", yq, 1'b1);
    din = 1'b0; ce = 1'b0; gsr = 1'b1; #1;
    chk("R9", "xq gsr", xq, 1'b1);
    chk("R9", "yq gsr", yq, 1'b0);
    tick();
    chk("R9", "xq gsr held", xq, 1'b1);
    chk("R9", "yq gsr held", yq, 1'b0);

    summary();
    $finish;
  end
endmodule